// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block converts between the non-return-to-zero bit stream of a UART and the return-to-zero light pulses used by a serial infrared link. On the transmit side, every zero bit becomes one short light pulse and every one bit leaves the emitter dark. On the receive side, a light pulse seen anywhere in a bit period produces a zero on the decoded line for the rest of that period. Framing stays in the UART. The codec only reshapes bits, using the UART's 16x oversampling tick as its time base.

Two pulse-width modes are available. In the normal mode the pulse spans three 16x ticks, which is 3/16 of a bit. In the low-power mode the pulse spans three periods of a reference tick that is divided down from the system clock by an 8-bit divisor. That width is set by the divisor and does not follow the bit rate. While the infrared path is off, the block passes the UART line straight through to the wired transmit pin and takes received bits from the wired receive pin. A loopback control ties the transmit path back into the receive path, for both the infrared path and the wired path.

Top module: `irda_sir_codec`

## Requirements
- R1: With `sir_en`=1 and normal mode, a `tx_bit` of 0 sampled on the 16x tick that opens a bit period produces `ir_tx`=1 (light) starting the next clock and lasting exactly 3 tick periods. Bit periods are 16 ticks, counted from the tick following enable or reset.
- R2: A `tx_bit` of 1 at the start of a bit period produces no pulse; `ir_tx` stays 0.
- R3: In low-power mode (`lp_mode`=1) with `lp_div`=N>0, a zero bit produces a pulse of exactly 3*N system clocks, whatever the tick rate.
- R4: In low-power mode with `lp_div`=0, no pulse is emitted and `div_invalid` reads 1 one clock later. `div_invalid` reads 0 one clock after the condition clears.
- R5: With `sir_en`=0, `ir_tx` is 0 from the next clock on, `ir_rx` has no effect, `rx_bit` follows `wire_rx`, `wire_tx` follows `tx_bit`, and re-enabling shows no stale decoded zero.
- R6: With `sir_en`=1, `wire_tx` is 1 (marking) and `wire_rx` has no effect on `rx_bit`.
- R7: `ir_rx` is active low (0 = light). With `sir_en`=1, a light level lasting at least one clock drives `rx_bit` to 0 within 3 clocks. `rx_bit` then stays 0 for 16 ticks after detection, and returns to 1 if no further pulse arrives.
- R8: With `sir_en`=1 and `loopback`=1, the inverted `ir_tx` replaces `ir_rx` as the receive input: a transmitted zero decodes as 0, a one decodes as 1, and `ir_rx` is ignored.
- R9: With `sir_en`=0 and `loopback`=1, `rx_bit` follows `tx_bit`.
- R10: During and right after reset, `ir_tx`=0 and `div_invalid`=0; with `sir_en`=1, `rx_bit`=1 and `wire_tx`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sir_en | input | 1 | 1 selects the infrared path, 0 the wired path |
| lp_mode | input | 1 | 1 selects low-power pulse width |
| loopback | input | 1 | Route the transmit path back into receive |
| lp_div | input | 8 | Low-power reference divisor, 0 is invalid |
| tick16 | input | 1 | One-clock strobe at 16x the bit rate |
| tx_bit | input | 1 | Serial transmit bit from the UART |
| wire_rx | input | 1 | Wired serial receive pin |
| ir_rx | input | 1 | Infrared receiver input, 0 = light |
| ir_tx | output | 1 | Infrared emitter drive, 1 = light |
| rx_bit | output | 1 | Decoded receive bit to the UART |
| wire_tx | output | 1 | Wired serial transmit pin |
| div_invalid | output | 1 | Low-power mode selected with a zero divisor |

## Verification
Bit patterns go through the encoder as all zeros, all ones, alternating bits and isolated zeros. Pulse counts show that ones never light the emitter, and that back-to-back zeros each get a separate pulse. The measured widths, 15 clocks in normal mode and 3, 6, 21 and 60 clocks for divisors 1, 2, 7 and 20, tell tick-timed pulses apart from divisor-timed ones, and a zero divisor must give no pulse at all. On the receive side, a single-clock light blip, a steady light level with loopback on, and loopback zeros and ones separate the external input from the looped path, and separate the held decoded zero from its release.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

   typedef enum logic [1:0] {
      PS_IDLE   = 2'd0,
      PS_NORMAL = 2'd1,
      PS_LOWPWR = 2'd2
   } pulse_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irda_lp_ref.sv
module irda_lp_ref #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] last_val;
   logic             div_zero;

   assign div_zero = (div_i == '0);
   assign last_val = div_i - {{(DIV_W-1){1'b0}}, 1'b1};
   assign tick_o   = !div_zero && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i || div_zero || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
      end
   end

endmodule

// File: rtl/irda_sir_enc.sv
module irda_sir_enc
   import irda_sir_pkg::*;
#(
   parameter int unsigned OVS        = 16,
   parameter int unsigned NORM_TICKS = 3,
   parameter int unsigned LP_TICKS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic lp_sel_i,
   input  logic div_ok_i,
   input  logic tick16_i,
   input  logic lp_tick_i,
   input  logic tx_bit_i,
   output logic pulse_o,
   output logic start_o
);

   localparam int unsigned PH_W   = cnt_width(OVS);
   localparam int unsigned MAXT   = (NORM_TICKS > LP_TICKS) ? NORM_TICKS : LP_TICKS;
   localparam int unsigned CNT_W  = cnt_width(MAXT + 1);
   localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(OVS - 1);
   localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_TICKS - 1);
   localparam logic [CNT_W-1:0] LP_LAST   = CNT_W'(LP_TICKS - 1);

   logic [PH_W-1:0]  phase_q;
   logic [CNT_W-1:0] cnt_q;
   pulse_state_e     state_q;
   logic             start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!en_i) begin
         phase_q <= '0;
      end else if (tick16_i) begin
         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + {{(PH_W-1){1'b0}}, 1'b1};
      end
   end

   assign start = en_i && tick16_i && (phase_q == '0) && !tx_bit_i
                  && (!lp_sel_i || div_ok_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         cnt_q   <= '0;
      end else if (!en_i) begin
         state_q <= PS_IDLE;
         cnt_q   <= '0;
      end else if (start) begin
         state_q <= lp_sel_i ? PS_LOWPWR : PS_NORMAL;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            PS_NORMAL: begin
               if (tick16_i) begin
                  if (cnt_q == NORM_LAST) begin
                     state_q <= PS_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
                  end
               end
            end
            PS_LOWPWR: begin
               if (lp_tick_i) begin
                  if (cnt_q == LP_LAST) begin
                     state_q <= PS_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
                  end
               end
            end
            default: begin
               state_q <= PS_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign pulse_o = (state_q != PS_IDLE);
   assign start_o = start;

endmodule

// File: rtl/irda_sir_dec.sv
module irda_sir_dec
   import irda_sir_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick16_i,
   input  logic din_n_i,
   output logic bit_o
);

   localparam int unsigned HC_W = cnt_width(OVS);
   localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(OVS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   light;
   logic                   light_q;
   logic                   light_edge;
   logic                   hold_q;
   logic [HC_W-1:0]        hcnt_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= din_n_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   assign light      = !sync_q[SYNC_STAGES-1];
   assign light_edge = light && !light_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) light_q <= 1'b0;
      else        light_q <= light;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         hcnt_q <= '0;
      end else if (!en_i) begin
         hold_q <= 1'b0;
         hcnt_q <= '0;
      end else if (light_edge) begin
         hold_q <= 1'b1;
         hcnt_q <= '0;
      end else if (hold_q && tick16_i) begin
         if (hcnt_q == HOLD_LAST) begin
            hold_q <= 1'b0;
            hcnt_q <= '0;
         end else begin
            hcnt_q <= hcnt_q + {{(HC_W-1){1'b0}}, 1'b1};
         end
      end
   end

   assign bit_o = !hold_q;

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned NORM_TICKS  = 3,
   parameter int unsigned LP_TICKS    = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LP_EN       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sir_en,
   input  logic             lp_mode,
   input  logic             loopback,
   input  logic [DIV_W-1:0] lp_div,
   input  logic             tick16,
   input  logic             tx_bit,
   input  logic             wire_rx,
   input  logic             ir_rx,
   output logic             ir_tx,
   output logic             rx_bit,
   output logic             wire_tx,
   output logic             div_invalid
);

   initial begin
      assert (OVS >= 4) else $error("OVS must be at least 4");
      assert (NORM_TICKS >= 1 && NORM_TICKS < OVS) else $error("NORM_TICKS out of range");
      assert (LP_TICKS >= 1) else $error("LP_TICKS must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (DIV_W >= 2) else $error("DIV_W must be at least 2");
   end

   logic lp_sel;
   logic div_ok;
   logic lp_tick;
   logic enc_start;
   logic enc_pulse;
   logic dec_in_n;
   logic dec_bit;
   logic inval_q;

   assign lp_sel = LP_EN && lp_mode;
   assign div_ok = (lp_div != '0);

   generate
      if (LP_EN) begin : g_lp
         irda_lp_ref #(.DIV_W(DIV_W)) u_lp_ref (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (enc_start),
            .div_i     (lp_div),
            .tick_o    (lp_tick)
         );
      end else begin : g_no_lp
         assign lp_tick = 1'b0;
      end
   endgenerate

   irda_sir_enc #(
      .OVS        (OVS),
      .NORM_TICKS (NORM_TICKS),
      .LP_TICKS   (LP_TICKS)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (sir_en),
      .lp_sel_i  (lp_sel),
      .div_ok_i  (div_ok),
      .tick16_i  (tick16),
      .lp_tick_i (lp_tick),
      .tx_bit_i  (tx_bit),
      .pulse_o   (enc_pulse),
      .start_o   (enc_start)
   );

   assign dec_in_n = loopback ? !enc_pulse : ir_rx;

   irda_sir_dec #(
      .OVS         (OVS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (sir_en),
      .tick16_i (tick16),
      .din_n_i  (dec_in_n),
      .bit_o    (dec_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inval_q <= 1'b0;
      else        inval_q <= lp_sel && !div_ok;
   end

   assign ir_tx       = enc_pulse;
   assign wire_tx     = sir_en ? 1'b1 : tx_bit;
   assign rx_bit      = sir_en ? dec_bit : (loopback ? tx_bit : wire_rx);
   assign div_invalid = inval_q;

endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk #(
   parameter int unsigned DIV_W = 8,
   parameter bit          LP_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sir_en,
   input logic             lp_mode,
   input logic [DIV_W-1:0] lp_div,
   input logic             tick16,
   input logic             tx_bit,
   input logic             ir_tx,
   input logic             wire_tx,
   input logic             div_invalid
);

   // R5: emitter goes dark the clock after the infrared path is turned off
   p_dark_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sir_en |=> !ir_tx);

   // R1: a pulse only begins after a tick that carried a zero bit
   p_rise_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ir_tx) |-> $past(tick16 && !tx_bit && sir_en));

   // R1: a normal-mode pulse ends on a 16x tick
   p_norm_end_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ir_tx) && $past(sir_en) && !$past(lp_mode)) |-> $past(tick16));

   // R6: wired line marks while infrared is active
   p_mark_when_sir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sir_en |-> wire_tx);

   generate
      if (LP_EN) begin : g_lp_chk
         // R4: a zero divisor in low-power mode never starts a pulse
         p_no_pulse_bad_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ir_tx) |-> !$past(lp_mode && (lp_div == '0)));

         // R4: flag raised one clock after the bad setting appears
         p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (lp_mode && (lp_div == '0)) |=> div_invalid);

         // R4: flag dropped one clock after the setting becomes valid
         p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(lp_mode && (lp_div == '0)) |=> !div_invalid);
      end
   endgenerate

endmodule

bind irda_sir_codec irda_sir_codec_chk #(
   .DIV_W (DIV_W),
   .LP_EN (LP_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sir_en      (sir_en),
   .lp_mode     (lp_mode),
   .lp_div      (lp_div),
   .tick16      (tick16),
   .tx_bit      (tx_bit),
   .ir_tx       (ir_tx),
   .wire_tx     (wire_tx),
   .div_invalid (div_invalid)
);

// File: tb/tb_irda_sir_codec.sv
module tb_irda_sir_codec;

   localparam int TICK_DIV = 5;
   localparam int NVEC     = 8;
   localparam int WD_LIMIT = 150000;

   // fields: [23] low-power, [22:15] divisor, [14:11] bits (MSB sent first),
   //         [10:8] expected pulse count, [7:0] expected width in clocks
   localparam logic [23:0] VEC [NVEC] = '{
      {1'b0, 8'd0,  4'b0101, 3'd2, 8'd15},
      {1'b0, 8'd0,  4'b1111, 3'd0, 8'd0 },
      {1'b0, 8'd0,  4'b0000, 3'd4, 8'd15},
      {1'b1, 8'd2,  4'b1010, 3'd2, 8'd6 },
      {1'b1, 8'd7,  4'b0110, 3'd2, 8'd21},
      {1'b1, 8'd20, 4'b0001, 3'd3, 8'd60},
      {1'b1, 8'd1,  4'b0011, 3'd2, 8'd3 },
      {1'b1, 8'd0,  4'b0000, 3'd0, 8'd0 }
   };

   logic       clk = 1'b0;
   logic       rst_n, sir_en, lp_mode, loopback, tx_bit, wire_rx, ir_rx;
   logic [7:0] lp_div;
   logic       tick16 = 1'b0;
   logic       ir_tx, rx_bit, wire_tx, div_invalid;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int tcnt   = 0;
   int bph    = 0;
   logic stat_clr = 1'b0;
   int npulse, run, minw, maxw;
   logic prev_ir = 1'b0;

   always #5 clk = ~clk;

   irda_sir_codec dut (
      .clk(clk), .rst_n(rst_n), .sir_en(sir_en), .lp_mode(lp_mode),
      .loopback(loopback), .lp_div(lp_div), .tick16(tick16), .tx_bit(tx_bit),
      .wire_rx(wire_rx), .ir_rx(ir_rx), .ir_tx(ir_tx), .rx_bit(rx_bit),
      .wire_tx(wire_tx), .div_invalid(div_invalid)
   );

   // tick source and model of the bit phase (16 ticks per bit from enable)
   always @(negedge clk) begin
      if (!rst_n || !sir_en) bph <= 0;
      else if (tick16)       bph <= (bph + 1) % 16;
      tick16 <= (tcnt == TICK_DIV - 1);
      tcnt   <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
   end

   // pulse monitor
   always @(negedge clk) begin
      if (stat_clr) begin
         npulse = 0; run = 0; minw = 255; maxw = 0;
      end else begin
         if (ir_tx) run = run + 1;
         if (!ir_tx && prev_ir) begin
            npulse = npulse + 1;
            if (run < minw) minw = run;
            if (run > maxw) maxw = run;
            run = 0;
         end
      end
      prev_ir = ir_tx;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         fails = fails + 1;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic nstep();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      while (bph == 8) nstep();
      while (bph != 8) nstep();
      tx_bit = b;
   endtask

   initial begin
      rst_n = 1'b0; sir_en = 1'b1; lp_mode = 1'b0; loopback = 1'b0;
      lp_div = 8'd0; tx_bit = 1'b1; wire_rx = 1'b1; ir_rx = 1'b1;
      repeat (3) nstep();
      chk("R10 ir_tx in reset", ir_tx, 0);
      chk("R10 rx_bit in reset", rx_bit, 1);
      chk("R10 div_invalid in reset", div_invalid, 0);
      chk("R10 wire_tx in reset", wire_tx, 1);
      rst_n = 1'b1;
      nstep();

      // table-driven encoder patterns
      for (int i = 0; i < NVEC; i++) begin
         string tag;
         logic  lp;
         logic [7:0] dv;
         lp = VEC[i][23];
         dv = VEC[i][22:15];
         if (lp && dv == 8'd0)          tag = "R4";
         else if (lp)                   tag = "R3";
         else if (VEC[i][10:8] == 3'd0) tag = "R2";
         else                           tag = "R1";
         lp_mode = lp; lp_div = dv;
         stat_clr = 1'b1; nstep(); stat_clr = 1'b0; nstep();
         chk({tag, " div_invalid"}, div_invalid, (lp && dv == 8'd0) ? 1 : 0);
         for (int k = 3; k >= 0; k--) send_bit(VEC[i][11 + k]);
         send_bit(1'b1);
         send_bit(1'b1);
         chk({tag, " pulse count"}, npulse, int'(VEC[i][10:8]));
         if (VEC[i][10:8] != 3'd0) begin
            chk({tag, " min width"}, minw, int'(VEC[i][7:0]));
            chk({tag, " max width"}, maxw, int'(VEC[i][7:0]));
         end
      end

      lp_mode = 1'b0; lp_div = 8'd0;
      nstep(); nstep();
      chk("R4 flag cleared", div_invalid, 0);

      // R6: wired pins inert while infrared active
      tx_bit = 1'b0; wire_rx = 1'b0;
      nstep(); nstep();
      chk("R6 wire_tx marking", wire_tx, 1);
      chk("R6 wire_rx ignored", rx_bit, 1);
      tx_bit = 1'b1; wire_rx = 1'b1;
      repeat (100) nstep();

      // R7: single-clock light blip
      chk("R7 idle high", rx_bit, 1);
      ir_rx = 1'b0; nstep(); ir_rx = 1'b1;
      repeat (3) nstep();
      chk("R7 decoded zero", rx_bit, 0);
      repeat (40) nstep();
      chk("R7 held low", rx_bit, 0);
      repeat (60) nstep();
      chk("R7 released", rx_bit, 1);

      // R8: infrared loopback, external input held at light
      loopback = 1'b1; nstep(); ir_rx = 1'b0;
      send_bit(1'b1);
      send_bit(1'b0);
      chk("R8 one decodes high", rx_bit, 1);
      send_bit(1'b1);
      chk("R8 zero decodes low", rx_bit, 0);
      send_bit(1'b1);
      chk("R8 one after zero", rx_bit, 1);
      ir_rx = 1'b1; nstep(); loopback = 1'b0;
      repeat (100) nstep();

      // R5: infrared path off
      sir_en = 1'b0; nstep();
      chk("R5 wire_tx follows one", wire_tx, 1);
      tx_bit = 1'b0; nstep();
      chk("R5 wire_tx follows zero", wire_tx, 0);
      stat_clr = 1'b1; nstep(); stat_clr = 1'b0;
      repeat (20) nstep();
      ir_rx = 1'b0; nstep();
      chk("R5 ir_rx ignored", rx_bit, 1);
      ir_rx = 1'b1;
      repeat (20) nstep();
      chk("R5 no pulses", npulse, 0);
      chk("R5 emitter dark", ir_tx, 0);
      wire_rx = 1'b0; nstep();
      chk("R5 rx follows wire low", rx_bit, 0);
      wire_rx = 1'b1; nstep();
      chk("R5 rx follows wire high", rx_bit, 1);

      // R9: wired loopback
      loopback = 1'b1; tx_bit = 1'b0; nstep();
      chk("R9 loop zero", rx_bit, 0);
      tx_bit = 1'b1; nstep();
      chk("R9 loop one", rx_bit, 1);
      loopback = 1'b0; nstep();

      // R5: re-enable shows no stale capture
      sir_en = 1'b1;
      repeat (5) nstep();
      chk("R5 no stale zero", rx_bit, 1);
      chk("R5 dark after enable", ir_tx, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule